// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one queued frame on a single open-drain CEC line. A frame is 1 to 16 bytes. After a request is accepted, the block waits until the line has been free for the requested number of bit periods. It then sends a start bit, followed by every byte as ten bits: eight data bits with the most significant bit first, an end-of-message bit, and an acknowledge slot. The block controls the line only through a pull-low enable. It reads the line back to find lost arbitration, a missing acknowledge, and an error signalled by another device that holds the line low.

All timing is counted in ticks of a 1 µs enable input, so the block runs from any system clock. The request is a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a cycle where both `req_valid` and `req_ready` are high. While `req_ready` is low the block applies no back-pressure of its own: `req_valid` and the request fields are simply ignored. Each frame ends with a one-cycle `done` pulse that carries a 2-bit status.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset the line is released (`line_pull_low`=0), `req_ready`=1 and `done`=0.
- R2: A request is accepted only while `req_ready`=1, and `req_ready` is low from the cycle after acceptance until the frame ends. A request presented while busy has no effect on the frame on the line.
- R3: The start bit begins only on a tick at which the line has been high for more than `req_free_bits`×T_BIT consecutive ticks since acceptance. A low tick restarts that count.
- R4: The start bit pulls the line low for T_START_LOW ticks and then releases it, for T_START_TOT ticks in total.
- R5: Every bit lasts T_BIT ticks. A 0 is pulled low for T_ZERO_LOW ticks and a 1 for T_ONE_LOW ticks. Bytes go out in order from byte 0 at `req_data[7:0]`, with data bits MSB first. Each byte is followed by an end-of-message bit that is 1 only on byte `req_len_m1`, and then by an acknowledge slot sent as 1.
- R6: If a 1 among the first four bits of byte 0 reads low T_SAMPLE ticks after the bit starts, the line is released at once and status 2 (arbitration lost) is reported.
- R7: In the acknowledge slot the line is sampled T_SAMPLE ticks after the bit starts. The destination is `req_data[3:0]`. For a directed frame (destination ≠ 15) a high level is a NACK. For a broadcast frame (destination = 15) a low level is a NACK. A NACK ends the frame at the end of that slot with status 1, even when bytes remain.
- R8: If the line reads low on the last tick of a sampled 1 bit (an initiator 1 or an acknowledge slot), status 3 (low drive) is reported. The line stays released, and `req_ready` returns only on a tick at which the line is high.
- R9: A frame whose every acknowledge slot passes ends at the end of the last slot with status 0 (OK).
- R10: `done` is high for exactly one cycle per frame, and `done_status` is valid in that cycle.
- R11: The line drive and `done` change only on clock edges at which `tick_us` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle 1 µs timing enable |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | High while idle; the request is taken when valid and ready are both high |
| req_data | input | 8*MAX_BYTES | Frame bytes; byte i sits at [8i+7:8i] |
| req_len_m1 | input | $clog2(MAX_BYTES) | Number of bytes minus one |
| req_free_bits | input | SFT_W | Required free time, in bit periods |
| line_in | input | 1 | Level read back from the bus |
| line_pull_low | output | 1 | 1 pulls the bus low |
| done | output | 1 | One-cycle end-of-frame pulse |
| done_status | output | 2 | 0 OK, 1 NACK, 2 arbitration lost, 3 low drive |

## Verification
Every decision is made on a clock edge at which `tick_us` is sampled high, and its result is visible right after that same edge. The pull-low output, `done` and `done_status` therefore move together, one register after the deciding tick. `req_ready` falls on the edge that accepts a request. The bench drives its inputs on the falling clock edge. It advances a tick-time reference model on the rising edge, using the same inputs and the same line level, and compares drive, ready, done and status on every falling edge. The follower on the bus (acknowledges, a competing initiator, an error pulse, a glitch during the free-time wait) is computed from the model's bit position one half-cycle ahead of the edge that samples it.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    TX_OK     = 2'd0,
    TX_NACK   = 2'd1,
    TX_ARB    = 2'd2,
    TX_LOWDRV = 2'd3
  } tx_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_START,
    PH_BIT,
    PH_HOLD
  } tx_phase_e;

endpackage

// File: rtl/cec_tx_free_timer.sv
// Measures how long the line has been high without a break while waiting.
module cec_tx_free_timer #(
  parameter int SFT_W  = 4,
  parameter int T_BIT  = 2400,
  parameter int FREE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SFT_W-1:0] load_bits,
  input  logic             clear,
  input  logic             tick,
  input  logic             line,
  output logic             met
);

  logic [SFT_W-1:0]  bits_q;
  logic [FREE_W-1:0] high_cnt;
  logic [FREE_W-1:0] limit;

  assign limit = FREE_W'(bits_q) * FREE_W'(T_BIT);
  assign met   = (high_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (load) begin
      bits_q <= load_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      high_cnt <= '0;
    end else if (tick) begin
      if (!line) begin
        high_cnt <= '0;
      end else if (high_cnt != '1) begin
        high_cnt <= high_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cec_tx_bit_timer.sv
// Tick counter within the current start bit or data bit, with decoded timing points.
module cec_tx_bit_timer #(
  parameter int TCNT_W      = 13,
  parameter int T_START_LOW = 3700,
  parameter int T_START_TOT = 4500,
  parameter int T_BIT       = 2400,
  parameter int T_ZERO_LOW  = 1500,
  parameter int T_ONE_LOW   = 600,
  parameter int T_SAMPLE    = 850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic start_low_win,
  output logic start_last,
  output logic sample_pt,
  output logic bit_last,
  output logic zero_low_win,
  output logic one_low_win
);

  logic [TCNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (tick && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign start_low_win = (cnt < TCNT_W'(T_START_LOW));
  assign start_last    = (cnt == TCNT_W'(T_START_TOT - 1));
  assign sample_pt     = (cnt == TCNT_W'(T_SAMPLE));
  assign bit_last      = (cnt == TCNT_W'(T_BIT - 1));
  assign zero_low_win  = (cnt < TCNT_W'(T_ZERO_LOW));
  assign one_low_win   = (cnt < TCNT_W'(T_ONE_LOW));

endmodule

// File: rtl/cec_tx_bit_src.sv
// Holds the frame and presents the current bit with its position flags.
module cec_tx_bit_src #(
  parameter int MAX_BYTES  = 16,
  parameter int LEN_W      = 4,
  parameter int BCAST_ADDR = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [8*MAX_BYTES-1:0] load_data,
  input  logic [LEN_W-1:0]       load_len_m1,
  input  logic                   advance,
  output logic                   cur_bit,
  output logic                   is_init,
  output logic                   is_ack,
  output logic                   is_last,
  output logic                   is_bcast
);

  localparam logic [3:0] POS_EOM = 4'd8;
  localparam logic [3:0] POS_ACK = 4'd9;

  logic [8*MAX_BYTES-1:0] msg_q;
  logic [LEN_W-1:0]       len_q;
  logic [LEN_W-1:0]       byte_q;
  logic [3:0]             pos_q;
  logic [7:0]             cur_byte;
  logic                   on_last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q  <= '0;
      len_q  <= '0;
      byte_q <= '0;
      pos_q  <= '0;
    end else if (load) begin
      msg_q  <= load_data;
      len_q  <= load_len_m1;
      byte_q <= '0;
      pos_q  <= '0;
    end else if (advance) begin
      if (pos_q == POS_ACK) begin
        pos_q  <= '0;
        byte_q <= byte_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign cur_byte     = msg_q[{byte_q, 3'b000} +: 8];
  assign on_last_byte = (byte_q == len_q);

  always_comb begin
    if (pos_q < POS_EOM) begin
      cur_bit = cur_byte[3'd7 - pos_q[2:0]];
    end else if (pos_q == POS_EOM) begin
      cur_bit = on_last_byte;
    end else begin
      cur_bit = 1'b1;
    end
  end

  assign is_init  = (byte_q == '0) && (pos_q < 4'd4);
  assign is_ack   = (pos_q == POS_ACK);
  assign is_last  = is_ack && on_last_byte;
  assign is_bcast = (msg_q[3:0] == 4'(BCAST_ADDR));

endmodule

// File: rtl/cec_tx_seq.sv
// Frame-level sequencer: free wait, start bit, data bits, sample and end checks.
module cec_tx_seq
  import cec_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       free_met,
  input  logic       start_low_win,
  input  logic       start_last,
  input  logic       sample_pt,
  input  logic       bit_last,
  input  logic       zero_low_win,
  input  logic       one_low_win,
  input  logic       cur_bit,
  input  logic       is_init,
  input  logic       is_ack,
  input  logic       is_last,
  input  logic       is_bcast,
  output logic       load,
  output logic       advance,
  output logic       timer_restart,
  output logic       free_clear,
  output logic       pull_low,
  output logic       done,
  output logic [1:0] done_status
);

  tx_phase_e  phase_q, phase_d;
  tx_status_e stat_q, fin_stat;
  logic       fin;
  logic       nack_q, nack_hit;
  logic       checked;

  assign req_ready  = (phase_q == PH_IDLE);
  assign load       = req_valid && req_ready;
  assign free_clear = (phase_q != PH_WAIT);
  assign checked    = cur_bit && (is_init || is_ack);

  always_comb begin
    phase_d       = phase_q;
    advance       = 1'b0;
    timer_restart = 1'b1;
    fin           = 1'b0;
    fin_stat      = TX_OK;
    nack_hit      = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (load) phase_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (tick && line && free_met) phase_d = PH_START;
      end
      PH_START: begin
        timer_restart = 1'b0;
        if (tick && start_last) begin
          phase_d       = PH_BIT;
          timer_restart = 1'b1;
        end
      end
      PH_BIT: begin
        timer_restart = 1'b0;
        if (tick && sample_pt && checked) begin
          if (is_init && !line) begin
            fin      = 1'b1;
            fin_stat = TX_ARB;
            phase_d  = PH_IDLE;
          end else if (is_ack && (line != is_bcast)) begin
            nack_hit = 1'b1;
          end
        end
        if (tick && bit_last) begin
          if (checked && !line) begin
            fin      = 1'b1;
            fin_stat = TX_LOWDRV;
            phase_d  = PH_HOLD;
          end else if (checked && is_ack && nack_q) begin
            fin      = 1'b1;
            fin_stat = TX_NACK;
            phase_d  = PH_IDLE;
          end else if (is_last) begin
            fin      = 1'b1;
            fin_stat = TX_OK;
            phase_d  = PH_IDLE;
          end else begin
            advance       = 1'b1;
            timer_restart = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (tick && line) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      stat_q  <= TX_OK;
      done    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done    <= fin;
      if (fin) stat_q <= fin_stat;
      if (load) begin
        nack_q <= 1'b0;
      end else if (nack_hit) begin
        nack_q <= 1'b1;
      end
    end
  end

  assign done_status = stat_q;

  always_comb begin
    pull_low = 1'b0;
    if (phase_q == PH_START) begin
      pull_low = start_low_win;
    end else if (phase_q == PH_BIT) begin
      pull_low = cur_bit ? one_low_win : zero_low_win;
    end
  end

endmodule

// File: rtl/cec_frame_tx.sv
// Top: wires the free-time timer, the bit timer, the bit source and the sequencer.
module cec_frame_tx #(
  parameter int MAX_BYTES   = 16,
  parameter int SFT_W       = 4,
  parameter int T_START_LOW = 3700,
  parameter int T_START_TOT = 4500,
  parameter int T_BIT       = 2400,
  parameter int T_ZERO_LOW  = 1500,
  parameter int T_ONE_LOW   = 600,
  parameter int T_SAMPLE    = 850,
  parameter int BCAST_ADDR  = 15,
  localparam int LEN_W      = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [8*MAX_BYTES-1:0] req_data,
  input  logic [LEN_W-1:0]       req_len_m1,
  input  logic [SFT_W-1:0]       req_free_bits,
  input  logic                   line_in,
  output logic                   line_pull_low,
  output logic                   done,
  output logic [1:0]             done_status
);

  localparam int T_LONG   = (T_START_TOT > T_BIT) ? T_START_TOT : T_BIT;
  localparam int TCNT_W   = $clog2(T_LONG + 1);
  localparam int FREE_MAX = ((2 ** SFT_W) - 1) * T_BIT;
  localparam int FREE_W   = $clog2(FREE_MAX + 2);

  logic load, advance, timer_restart, free_clear, free_met;
  logic start_low_win, start_last, sample_pt, bit_last, zero_low_win, one_low_win;
  logic cur_bit, is_init, is_ack, is_last, is_bcast;

  cec_tx_free_timer #(
    .SFT_W (SFT_W),
    .T_BIT (T_BIT),
    .FREE_W(FREE_W)
  ) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_bits(req_free_bits),
    .clear    (free_clear),
    .tick     (tick_us),
    .line     (line_in),
    .met      (free_met)
  );

  cec_tx_bit_timer #(
    .TCNT_W     (TCNT_W),
    .T_START_LOW(T_START_LOW),
    .T_START_TOT(T_START_TOT),
    .T_BIT      (T_BIT),
    .T_ZERO_LOW (T_ZERO_LOW),
    .T_ONE_LOW  (T_ONE_LOW),
    .T_SAMPLE   (T_SAMPLE)
  ) u_btim (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (timer_restart),
    .tick         (tick_us),
    .start_low_win(start_low_win),
    .start_last   (start_last),
    .sample_pt    (sample_pt),
    .bit_last     (bit_last),
    .zero_low_win (zero_low_win),
    .one_low_win  (one_low_win)
  );

  cec_tx_bit_src #(
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .BCAST_ADDR(BCAST_ADDR)
  ) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_data  (req_data),
    .load_len_m1(req_len_m1),
    .advance    (advance),
    .cur_bit    (cur_bit),
    .is_init    (is_init),
    .is_ack     (is_ack),
    .is_last    (is_last),
    .is_bcast   (is_bcast)
  );

  cec_tx_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_us),
    .line         (line_in),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .free_met     (free_met),
    .start_low_win(start_low_win),
    .start_last   (start_last),
    .sample_pt    (sample_pt),
    .bit_last     (bit_last),
    .zero_low_win (zero_low_win),
    .one_low_win  (one_low_win),
    .cur_bit      (cur_bit),
    .is_init      (is_init),
    .is_ack       (is_ack),
    .is_last      (is_last),
    .is_bcast     (is_bcast),
    .load         (load),
    .advance      (advance),
    .timer_restart(timer_restart),
    .free_clear   (free_clear),
    .pull_low     (line_pull_low),
    .done         (done),
    .done_status  (done_status)
  );

endmodule

// File: rtl/cec_frame_tx_chk.sv
module cec_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_us,
  input logic       req_valid,
  input logic       req_ready,
  input logic       line_pull_low,
  input logic       done,
  input logic [1:0] done_status
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_drive_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> !req_ready);

  p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_us |=> ($stable(line_pull_low) && !done));

  p_release_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !line_pull_low);

  p_lowdrv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 2'd3) |-> (!line_pull_low && !req_ready));

endmodule

bind cec_frame_tx cec_frame_tx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_us      (tick_us),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .line_pull_low(line_pull_low),
  .done         (done),
  .done_status  (done_status)
);

// File: tb/sim_cec_frame_tx.sv
`timescale 1ns/1ps
module sim_cec_frame_tx;
  localparam int MB = 16, LW = 4, SW = 4;
  localparam int TSL = 74, TST = 90, TB = 48, T0 = 30, T1 = 12, TS = 17;

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0, req_valid = 1'b0;
  logic [8*MB-1:0] req_data = '0;
  logic [LW-1:0] req_len_m1 = '0;
  logic [SW-1:0] req_free_bits = '0;
  logic other_low = 1'b0;
  logic line_in, line_pull_low, req_ready, done;
  logic [1:0] done_status;

  assign line_in = !(line_pull_low || other_low);
  always #2 clk = ~clk;

  cec_frame_tx #(.MAX_BYTES(MB), .SFT_W(SW), .T_START_LOW(TSL), .T_START_TOT(TST),
    .T_BIT(TB), .T_ZERO_LOW(T0), .T_ONE_LOW(T1), .T_SAMPLE(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_len_m1(req_len_m1), .req_free_bits(req_free_bits),
    .line_in(line_in), .line_pull_low(line_pull_low), .done(done), .done_status(done_status));

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // follower configuration
  int ack_mask = 0, arb_bit = -1, ld_bit = -1, gl_at = -1;

  // reference model, tick-time based
  int ms = 0, hi = 0, t = 0, nbits = 0, sft = 0, ldc = 0, glc = 0, e_stat = 0;
  bit e_pull = 0, e_done = 0, bc = 0, nk = 0, gl_arm = 0;
  int mbits [0:10*MB-1];

  function automatic bit model_pull();
    int b, off;
    if (ms != 2) return 1'b0;
    if (t < TST) return (t < TSL);
    b   = (t - TST) / TB;
    off = (t - TST) % TB;
    return off < (mbits[b] ? T1 : T0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; e_pull = 0; e_done = 0; nk = 0;
    end else begin
      bit ln, ck;
      int b, off, nb;
      ln = !(e_pull || other_low);
      e_done = 0;
      case (ms)
        0: if (req_valid) begin
          nb = int'(req_len_m1) + 1;
          for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < 8; k++) mbits[i*10+k] = req_data[8*i+7-k];
            mbits[i*10+8] = (i == nb - 1);
            mbits[i*10+9] = 1;
          end
          nbits = nb * 10; bc = (req_data[3:0] == 4'hF); sft = int'(req_free_bits);
          nk = 0; hi = 0; glc = 0; gl_arm = (gl_at >= 0); ms = 1;
        end
        1: if (tick_us) begin
          if (glc > 0) glc--;
          if (ln && hi >= sft * TB) begin
            ms = 2; t = 0;
          end else begin
            hi = ln ? hi + 1 : 0;
            if (gl_arm && hi == gl_at) begin glc = 3; gl_arm = 0; end
          end
        end
        2: if (tick_us) begin
          if (t >= TST) begin
            b = (t - TST) / TB; off = (t - TST) % TB;
            ck = mbits[b] && (b < 4 || b % 10 == 9);
            if (ck && off == TS) begin
              if (b < 4 && !ln) begin e_done = 1; e_stat = 2; ms = 0; end
              else if (b % 10 == 9 && (bc ? !ln : ln)) nk = 1;
            end
            if (ms == 2 && off == TB - 1) begin
              if (ck && !ln) begin e_done = 1; e_stat = 3; ms = 3; ldc = 20; end
              else if (ck && nk) begin e_done = 1; e_stat = 1; ms = 0; end
              else if (b == nbits - 1) begin e_done = 1; e_stat = 0; ms = 0; end
            end
          end
          if (ms == 2) t++;
        end
        3: if (tick_us) begin
          if (ln) ms = 0;
          else if (ldc > 0) ldc--;
        end
        default: ms = 0;
      endcase
      e_pull = model_pull();
    end
  end

  function automatic string stat_tag(int s);
    case (s)
      0: return "R9 ok status";
      1: return "R7 nack status";
      2: return "R6 arbitration status";
      default: return "R8 low-drive status";
    endcase
  endfunction

  // compare and drive the bus follower on the falling edge
  always @(negedge clk) begin
    int b, off;
    string ptag;
    cyc++;
    tick_us = (cyc % 3) != 0;
    if (rst_n) begin
      ptag = (ms == 2) ? ((t < TST) ? "R4 start bit drive" : "R5 data bit drive")
           : (ms == 1) ? "R3 free-wait drive" : "R8 released drive";
      chk(line_pull_low == e_pull, ptag, int'(line_pull_low), int'(e_pull));
      chk(req_ready == (ms == 0), "R2 ready", int'(req_ready), int'(ms == 0));
      chk(done == e_done, "R10 done pulse", int'(done), int'(e_done));
      if (e_done) chk(done_status == 2'(e_stat), stat_tag(e_stat), int'(done_status), e_stat);
    end
    other_low = 1'b0;
    if (ms == 1) begin
      other_low = (glc > 0);
    end else if (ms == 3) begin
      other_low = (ldc > 0);
    end else if (ms == 2 && t >= TST) begin
      b = (t - TST) / TB; off = (t - TST) % TB;
      if (b % 10 == 9 && ack_mask[b/10] && off < T0) other_low = 1'b1;
      if (b == arb_bit && off < T0) other_low = 1'b1;
      if (b == ld_bit && off > TS) other_low = 1'b1;
    end
  end

  task automatic launch(logic [8*MB-1:0] d, int len, int fb);
    @(negedge clk);
    req_data = d; req_len_m1 = LW'(len - 1); req_free_bits = SW'(fb); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_frame(int exp, string tag);
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    if (!done) begin
      chk(0, "watchdog frame end", 0, 1);
    end else begin
      chk(done_status == 2'(exp), tag, int'(done_status), exp);
      @(negedge clk);
      chk(!done, "R10 single-cycle done", int'(done), 0);
    end
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [8*MB-1:0] pk(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    logic [8*MB-1:0] d = '0;
    d[7:0] = b0; d[15:8] = b1; d[23:16] = b2;
    return d;
  endfunction

  initial begin
    logic [8*MB-1:0] big;
    int nt;
    repeat (4) @(negedge clk);
    chk(line_pull_low == 1'b0, "R1 reset drive", int'(line_pull_low), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    // directed frame, all acknowledged, with a request issued while busy (R9, R2)
    ack_mask = '1;
    launch(pk(8'h41, 8'hA5, 8'h00), 2, 1);
    repeat (300) @(negedge clk);
    req_data = '1; req_len_m1 = '1; req_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 busy request ignored", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    finish_frame(0, "R9 directed ok");

    // broadcast, nobody pulls the acknowledge low (R7)
    ack_mask = 0;
    launch(pk(8'h4F, 8'h36, 8'h00), 2, 2);
    finish_frame(0, "R7 broadcast ok");

    // broadcast, a follower rejects byte 0 (R7)
    ack_mask = 1;
    launch(pk(8'h4F, 8'h36, 8'h11), 3, 1);
    finish_frame(1, "R7 broadcast nack stops early");

    // directed, byte 1 not acknowledged (R7)
    ack_mask = 1;
    launch(pk(8'h41, 8'h82, 8'h10), 3, 1);
    finish_frame(1, "R7 directed nack");

    // competing initiator wins on bit 1 (R6)
    ack_mask = '1; arb_bit = 1;
    launch(pk(8'h71, 8'h00, 8'h00), 2, 1);
    finish_frame(2, "R6 arbitration lost");
    arb_bit = -1;

    // error pulse after the sample point of bit 1 (R8)
    ld_bit = 1;
    launch(pk(8'h41, 8'h22, 8'h00), 2, 1);
    finish_frame(3, "R8 low drive");
    ld_bit = -1;

    // glitch during the free-time wait restarts the count (R3)
    gl_at = 20;
    launch(pk(8'h52, 8'h00, 8'h00), 1, 1);
    nt = 0;
    while (nt < 60) begin @(posedge clk); if (tick_us) nt++; end
    @(negedge clk);
    chk(line_pull_low == 1'b0, "R3 wait restarted by low", int'(line_pull_low), 0);
    finish_frame(0, "R3 frame after glitch ok");
    gl_at = -1;

    // longest frame (R5)
    big = '0;
    for (int i = 0; i < MB; i++) big[8*i +: 8] = 8'(i * 17 + 3);
    launch(big, MB, 0);
    finish_frame(0, "R5 sixteen-byte frame");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule